// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial EEPROM link. It drives the chip select, the serial clock and the serial data line toward the memory, and it captures the memory's serial data output. A client starts a command by presenting a command code, an address, a write word and a read word count together with a request strobe for one cycle. The controller then builds the whole serial frame: a start bit, a two-bit opcode, an eight-bit field that carries either the address or an extended sub-command, and, for the two write forms, a sixteen-bit data word.

The serial clock comes from the system clock through a divider parameter, so each half period lasts a fixed number of system cycles. Chip select is held low for a programmable minimum number of cycles before each frame. Read commands keep clocking past the address for as many words as requested, because the memory steps its address on its own. The controller skips the dummy zero bit that comes before the first word and returns every word with a one-cycle valid strobe. After any command that programs the array, the controller waits a programmable write cycle time before it reports done. Busy covers the whole command, and requests that arrive while busy are dropped.

Top module: `uwire_host`

## Requirements
- R1: While reset is held and whenever busy is low, cs, sk, di, done and rd_valid are all low.
- R2: Each frame opens with di = 1 on the first serial clock rise after cs goes high. Two opcode bits follow, most significant first: 10 for read (req_cmd 0), 01 for write (req_cmd 1), 11 for erase (req_cmd 2), and 00 for every extended command.
- R3: For read, write and erase the eight-bit field after the opcode is a 0 bit followed by the 7-bit req_addr, most significant bit first.
- R4: For the extended commands the eight-bit field is 11 for write enable (req_cmd 3), 00 for write disable (req_cmd 4 and 7), 01 for write-all (req_cmd 5) or 10 for erase-all (req_cmd 6), followed by six 0 bits. Enable, disable and erase-all frames are exactly 11 serial clocks long.
- R5: Write and write-all append req_wdata most significant bit first, giving a 27-clock frame.
- R6: Every high half and every low half of sk lasts at least CLK_DIV system cycles, and di never changes while sk is high.
- R7: Before every rise of cs, including the first after reset, cs has been low for at least CS_LOW_CYC system cycles.
- R8: A read clocks 12 + 16*N rises, where N is req_count and a count of 0 means one word. di stays 0 after the header. do_in is sampled on each sk rise, the bit after the address is discarded, and each following group of 16 bits is returned most significant bit first on rd_data with a one-cycle rd_valid. The memory's address roll-over from 127 to 0 passes through unchanged.
- R9: After write, erase, write-all or erase-all, done rises exactly WR_WAIT_CYC cycles after cs falls. After read, enable or disable, done rises in the same cycle that cs falls.
- R10: busy goes high in the cycle after a request is accepted and stays high through the single cycle in which done is high, then drops. A request presented while busy starts no frame and does not disturb the running one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe, taken only while idle |
| req_cmd | input | 3 | Command code (0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 write-all, 6 erase-all) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to program for write and write-all |
| req_count | input | CNT_W | Number of words to read, 0 meaning one |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle strobe for each read word |
| rd_data | output | DATA_W | Read word |
| cs | output | 1 | Chip select to the memory |
| sk | output | 1 | Serial clock to the memory |
| di | output | 1 | Serial data toward the memory |
| do_in | input | 1 | Serial data from the memory |

## Verification
The bench builds the controller with CLK_DIV = 2, CS_LOW_CYC = 5 and WR_WAIT_CYC = 40, and keeps the default 7-bit address, 16-bit word and 4-bit count. With these short timings, the full write-cycle wait, the minimum chip-select gap between back-to-back commands and a fifteen-word burst all fit in a short run. A behavioural memory model on the serial pins records every frame and serves an address-derived pattern that wraps from the top address to zero. Half-period and gap minima are measured exactly at their limits.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_WREN  = 3'd3,
        CMD_WRDIS = 3'd4,
        CMD_FILL  = 3'd5,
        CMD_WIPE  = 3'd6
    } uw_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SHIFT,
        ST_WAIT,
        ST_FIN
    } uw_state_e;

    typedef struct packed {
        logic rd;    // read burst: collect words after the dummy bit
        logic prog;  // programs the array: wait out the write cycle
    } uw_job_t;

    // Two-bit opcode sent right after the start bit.
    function automatic logic [1:0] op_bits(logic [2:0] c);
        case (c)
            CMD_READ:  return 2'b10;
            CMD_WRITE: return 2'b01;
            CMD_ERASE: return 2'b11;
            default:   return 2'b00;
        endcase
    endfunction

    // Sub-command code in the top of the field for the 00 opcode group.
    function automatic logic [1:0] ext_bits(logic [2:0] c);
        case (c)
            CMD_WREN: return 2'b11;
            CMD_FILL: return 2'b01;
            CMD_WIPE: return 2'b10;
            default:  return 2'b00;
        endcase
    endfunction

    function automatic logic is_ext(logic [2:0] c);
        return c >= 3'd3;
    endfunction

    function automatic logic is_prog(logic [2:0] c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_FILL) || (c == CMD_WIPE);
    endfunction

    function automatic logic has_payload(logic [2:0] c);
        return (c == CMD_WRITE) || (c == CMD_FILL);
    endfunction

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uwire_shift.sv
module uwire_shift #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] d,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= d;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb = sr[W-1];
endmodule

// File: rtl/uwire_collect.sv
module uwire_collect #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              smp,
    input  logic              bit_in,
    output logic              valid,
    output logic [DATA_W-1:0] word
);
    localparam int BW = $clog2(DATA_W + 1);

    logic [BW-1:0]     bitcnt;
    logic [DATA_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bitcnt <= '0;
            acc    <= '0;
            valid  <= 1'b0;
            word   <= '0;
        end else begin
            valid <= 1'b0;
            if (smp) begin
                acc <= {acc[DATA_W-2:0], bit_in};
                if (bitcnt == BW'(DATA_W - 1)) begin
                    bitcnt <= '0;
                    valid  <= 1'b1;
                    word   <= {acc[DATA_W-2:0], bit_in};
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uwire_host.sv
module uwire_host
    import uwire_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 4,
    parameter int CLK_DIV     = 50,
    parameter int CS_LOW_CYC  = 46,
    parameter int WR_WAIT_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  req_count,
    output logic              busy,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cs,
    output logic              sk,
    output logic              di,
    input  logic              do_in
);
    localparam int FIELD_W = ADDR_W + 1;
    localparam int HDR_W   = 3 + FIELD_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int RISE_W  = $clog2(HDR_W + 2 + DATA_W * (2 ** CNT_W));
    localparam int GAP_W   = $clog2(CS_LOW_CYC + 1);
    localparam int WAIT_W  = $clog2(WR_WAIT_CYC + 1);

    uw_state_e         state;
    uw_job_t           job;
    logic [RISE_W-1:0] n_rise, rise_cnt, n_rise_next;
    logic [GAP_W-1:0]  gap_cnt;
    logic [WAIT_W-1:0] wait_cnt;
    logic              cs_q, sk_q, tick, frame_msb;
    logic [FIELD_W-1:0] field;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W:0]     words;

    wire accept = (state == ST_IDLE) && req_valid;
    wire rise   = (state == ST_SHIFT) && tick && !sk_q;
    wire fall   = (state == ST_SHIFT) && tick && sk_q && (rise_cnt != n_rise);
    wire smp    = rise && job.rd && (rise_cnt >= RISE_W'(HDR_W + 1));

    // Frame assembly from the request fields.
    always_comb begin
        if (is_ext(req_cmd)) begin
            field = {ext_bits(req_cmd), {(FIELD_W - 2){1'b0}}};
        end else begin
            field = {1'b0, req_addr};
        end
        frame = {1'b1, op_bits(req_cmd), field,
                 has_payload(req_cmd) ? req_wdata : {DATA_W{1'b0}}};
        words = (req_count == '0) ? (CNT_W + 1)'(1) : {1'b0, req_count};
        n_rise_next = RISE_W'(HDR_W);
        if (has_payload(req_cmd)) begin
            n_rise_next = n_rise_next + RISE_W'(DATA_W);
        end
        if (req_cmd == CMD_READ) begin
            n_rise_next = n_rise_next + RISE_W'(1) + RISE_W'(DATA_W) * RISE_W'(words);
        end
    end

    uwire_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SHIFT),
        .tick (tick)
    );

    uwire_shift #(.W(FRAME_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (fall),
        .d     (frame),
        .msb   (frame_msb)
    );

    uwire_collect #(.DATA_W(DATA_W)) u_collect (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .smp    (smp),
        .bit_in (do_in),
        .valid  (rd_valid),
        .word   (rd_data)
    );

    // Cycles spent with chip select low, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (rst || cs_q) begin
            gap_cnt <= '0;
        end else if (gap_cnt != GAP_W'(CS_LOW_CYC)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            job      <= '0;
            n_rise   <= '0;
            rise_cnt <= '0;
            wait_cnt <= '0;
            cs_q     <= 1'b0;
            sk_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        job.rd   <= (req_cmd == CMD_READ);
                        job.prog <= is_prog(req_cmd);
                        n_rise   <= n_rise_next;
                        rise_cnt <= '0;
                        state    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(CS_LOW_CYC)) begin
                        cs_q  <= 1'b1;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sk_q) begin
                            sk_q     <= 1'b1;
                            rise_cnt <= rise_cnt + 1'b1;
                        end else begin
                            sk_q <= 1'b0;
                            if (rise_cnt == n_rise) begin
                                cs_q     <= 1'b0;
                                wait_cnt <= '0;
                                state    <= job.prog ? ST_WAIT : ST_FIN;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt == WAIT_W'(WR_WAIT_CYC - 1)) begin
                        state <= ST_FIN;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cs   = cs_q;
    assign sk   = sk_q;
    assign di   = cs_q & frame_msb;
    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);
endmodule

// File: rtl/uwire_host_chk.sv
module uwire_host_chk #(
    parameter int CLK_DIV    = 50,
    parameter int CS_LOW_CYC = 46
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic rd_valid,
    input logic cs,
    input logic sk,
    input logic di
);
    logic [15:0] low_run;
    logic [15:0] sk_run;
    logic        sk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            sk_run  <= '0;
            sk_prev <= 1'b0;
        end else begin
            sk_prev <= sk;
            if (cs) begin
                low_run <= '0;
            end else if (low_run != 16'hFFFF) begin
                low_run <= low_run + 1'b1;
            end
            if (sk != sk_prev) begin
                sk_run <= 16'd1;
            end else if (sk_run != 16'hFFFF) begin
                sk_run <= sk_run + 1'b1;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cs && !sk && !rd_valid && !done));

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs) |-> di);

    p_sk_half_r6: assert property (@(posedge clk) disable iff (rst)
        (sk != $past(sk)) |-> (sk_run >= 16'(CLK_DIV)));

    p_di_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sk && $past(sk)) |-> $stable(di));

    p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs) |-> (low_run >= 16'(CS_LOW_CYC)));

    p_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && req_valid) |=> busy);
endmodule

bind uwire_host uwire_host_chk #(
    .CLK_DIV    (CLK_DIV),
    .CS_LOW_CYC (CS_LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .cs        (cs),
    .sk        (sk),
    .di        (di)
);

// File: tb/sim_uwire_host.sv
module sim_uwire_host;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 2;
    localparam int GAP   = 5;
    localparam int WWAIT = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  req_count = '0;
    logic        busy, done, rd_valid, cs, sk, di;
    logic [15:0] rd_data;
    logic        do_in = 1'b0;

    uwire_host #(
        .ADDR_W(7), .DATA_W(16), .CNT_W(4),
        .CLK_DIV(DIV), .CS_LOW_CYC(GAP), .WR_WAIT_CYC(WWAIT)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
        .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
        .cs(cs), .sk(sk), .di(di), .do_in(do_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [6:0] a);
        return {8'(a) ^ 8'hA5, ~{1'b0, a}};
    endfunction

    // Behavioural memory on the serial pins.
    int          m_cnt = 0, m_pos = 0, frames = 0, last_cnt = 0;
    logic [10:0] m_hdr = '0, last_hdr = '0;
    logic [63:0] m_bits = '0, last_bits = '0;
    logic        m_rd = 1'b0;
    logic [6:0]  m_addr = '0;
    logic [15:0] m_word;

    always @(posedge sk or negedge cs) begin
        if (!cs) begin
            if (m_cnt != 0) begin
                frames++;
                last_cnt  = m_cnt;
                last_hdr  = m_hdr;
                last_bits = m_bits;
            end
            m_cnt  = 0;
            m_rd   = 1'b0;
            m_bits = '0;
            do_in <= 1'b0;
        end else begin
            if (m_cnt == 10) begin
                m_hdr = {m_bits[9:0], di};
                if (m_hdr[10:8] == 3'b110) begin
                    m_rd   = 1'b1;
                    m_addr = m_hdr[6:0];
                    m_pos  = 0;
                end
                do_in <= 1'b0;
            end else if (m_rd) begin
                m_word = pat(m_addr + 7'(m_pos / 16));
                do_in <= m_word[15 - (m_pos % 16)];
                m_pos++;
            end
            m_bits = {m_bits[62:0], di};
            m_cnt++;
        end
    end

    // Serial timing monitor.
    int   min_half = 1000, min_gap = 1000, di_bad = 0, run = 0, lowrun = 0;
    logic p_sk = 1'b0, p_cs = 1'b0, p_di = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cs && !p_cs) begin
                if (lowrun < min_gap) min_gap = lowrun;
                run = 1;
            end else if (sk != p_sk) begin
                if (run < min_half) min_half = run;
                run = 1;
            end else begin
                run++;
            end
            lowrun = cs ? 0 : lowrun + 1;
            if (sk && p_sk && (di != p_di)) di_bad++;
            p_sk = sk;
            p_cs = cs;
            p_di = di;
        end
    end

    logic [15:0] rd_buf [16];
    int          nrd = 0;

    task automatic run_cmd(input logic [2:0] c, input logic [6:0] a,
                           input logic [15:0] d, input logic [3:0] n,
                           input bit poke, output int lag);
        logic pc;
        int   k;
        nrd = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = c;
        req_addr  = a;
        req_wdata = d;
        req_count = n;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10", "busy after accept", busy, 1);
        pc  = cs;
        lag = 0;
        k   = 0;
        while (!done && k < 20000) begin
            if (rd_valid && nrd < 16) begin
                rd_buf[nrd] = rd_data;
                nrd++;
            end
            if (poke && k == 6) begin
                req_valid = 1'b1;
                req_cmd   = 3'd1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            k++;
            if (pc && !cs) lag = 0;
            else lag++;
            pc = cs;
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R10", "done reached", done, 1);
        @(negedge clk);
        check(!done && !busy, "R10", "done single cycle then idle", {done, busy}, 0);
    endtask

    task automatic t_enable;
        int lag, f0;
        f0 = frames;
        run_cmd(3'd3, 7'h55, 16'hFFFF, 4'd0, 0, lag);
        check(frames == f0 + 1, "R4", "enable frame count", frames, f0 + 1);
        check(last_hdr == 11'b100_11000000, "R4", "enable header", last_hdr, 11'b100_11000000);
        check(last_cnt == 11, "R4", "enable length", last_cnt, 11);
        check(lag == 0, "R9", "enable done lag", lag, 0);
    endtask

    task automatic t_write;
        int lag;
        run_cmd(3'd1, 7'h2B, 16'hC3A5, 4'd0, 0, lag);
        check(last_hdr == {1'b1, 2'b01, 1'b0, 7'h2B}, "R3", "write header",
              last_hdr, {1'b1, 2'b01, 1'b0, 7'h2B});
        check(last_cnt == 27, "R5", "write length", last_cnt, 27);
        check(last_bits[15:0] == 16'hC3A5, "R5", "write data", last_bits[15:0], 16'hC3A5);
        check(lag >= WWAIT && lag <= WWAIT + 2, "R9", "write cycle wait", lag, WWAIT);
    endtask

    task automatic t_erase;
        int lag;
        run_cmd(3'd2, 7'h7F, 16'h1234, 4'd0, 0, lag);
        check(last_hdr == {1'b1, 2'b11, 1'b0, 7'h7F}, "R2", "erase header",
              last_hdr, {1'b1, 2'b11, 1'b0, 7'h7F});
        check(last_cnt == 11, "R2", "erase length", last_cnt, 11);
        check(lag >= WWAIT && lag <= WWAIT + 2, "R9", "erase wait", lag, WWAIT);
    endtask

    task automatic t_fill;
        int lag;
        run_cmd(3'd5, 7'h11, 16'h8001, 4'd0, 0, lag);
        check(last_hdr == 11'b100_01000000, "R4", "write-all header", last_hdr, 11'b100_01000000);
        check(last_cnt == 27, "R5", "write-all length", last_cnt, 27);
        check(last_bits[15:0] == 16'h8001, "R5", "write-all data", last_bits[15:0], 16'h8001);
        check(lag >= WWAIT && lag <= WWAIT + 2, "R9", "write-all wait", lag, WWAIT);
    endtask

    task automatic t_wipe;
        int lag;
        run_cmd(3'd6, 7'h00, 16'h0000, 4'd0, 0, lag);
        check(last_hdr == 11'b100_10000000, "R4", "erase-all header", last_hdr, 11'b100_10000000);
        check(last_cnt == 11, "R4", "erase-all length", last_cnt, 11);
        check(lag >= WWAIT && lag <= WWAIT + 2, "R9", "erase-all wait", lag, WWAIT);
    endtask

    task automatic t_disable;
        int lag;
        run_cmd(3'd4, 7'h7F, 16'hFFFF, 4'd0, 0, lag);
        check(last_hdr == 11'b100_00000000, "R4", "disable header", last_hdr, 11'b100_00000000);
        check(last_cnt == 11, "R4", "disable length", last_cnt, 11);
        check(lag == 0, "R9", "disable done lag", lag, 0);
    endtask

    task automatic t_read(input logic [6:0] a, input logic [3:0] n);
        int lag, nw;
        nw = (n == 0) ? 1 : int'(n);
        run_cmd(3'd0, a, 16'hFFFF, n, 0, lag);
        check(last_hdr == {1'b1, 2'b10, 1'b0, a}, "R3", "read header",
              last_hdr, {1'b1, 2'b10, 1'b0, a});
        check(last_cnt == 12 + 16 * nw, "R8", "read clock count", last_cnt, 12 + 16 * nw);
        check(last_bits[15:0] == 16'h0, "R8", "di low during read", last_bits[15:0], 0);
        check(nrd == nw, "R8", "read word count", nrd, nw);
        for (int i = 0; i < nw && i < nrd; i++) begin
            check(rd_buf[i] == pat(a + 7'(i)), "R8", "read word", rd_buf[i], pat(a + 7'(i)));
        end
        check(lag == 0, "R9", "read done lag", lag, 0);
    endtask

    task automatic t_ignore;
        int lag, f0;
        f0 = frames;
        run_cmd(3'd0, 7'h33, 16'hAAAA, 4'd2, 1, lag);
        repeat (20) @(negedge clk);
        check(frames == f0 + 1, "R10", "request while busy ignored", frames, f0 + 1);
        check(!busy && !cs, "R10", "idle after ignored request", {busy, cs}, 0);
        check(nrd == 2 && rd_buf[0] == pat(7'h33) && rd_buf[1] == pat(7'h34), "R10",
              "burst intact", rd_buf[1], pat(7'h34));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({cs, sk, di, busy, done, rd_valid} == 6'b0, "R1", "outputs in reset",
              {cs, sk, di, busy, done, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({cs, sk, di, busy, done, rd_valid} == 6'b0, "R1", "idle after reset",
              {cs, sk, di, busy, done, rd_valid}, 0);
        t_enable();
        t_write();
        t_erase();
        t_fill();
        t_wipe();
        t_disable();
        t_read(7'h10, 4'd1);
        t_read(7'h7E, 4'd3);
        t_read(7'h05, 4'd0);
        t_read(7'h00, 4'd15);
        t_ignore();
        check(min_half >= DIV, "R6", "minimum sk half period", min_half, DIV);
        check(di_bad == 0, "R6", "di change while sk high", di_bad, 0);
        check(min_gap >= GAP, "R7", "minimum cs low gap", min_gap, GAP);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule